// File: doc/BRIEF.md
# HMAC Key Vector Register Bank

This block holds the secret key for a downstream HMAC engine. Software writes the key as sixteen 32-bit words through a simple write port. The bank assembles those words into one 512-bit key vector. The most significant word sits at the highest key address. A one-bit byte-order setting can reverse the bytes of each incoming word before the word is stored. With it, software can load a key held in memory order without first reordering it.

The engine uses the key only after software has written all sixteen words since the last clear. A 16-bit record of written words drives the key-valid output, so a partly loaded key is never presented as usable. Software pads a shorter key with zero words. A clear strobe wipes the whole vector in one cycle. Key words always read back as zero, so the key cannot leak over the register interface.

Top module: `hmac_key_bank`

## Requirements
- R1: After reset, `key_vec` is all zero, `key_valid` is 0 and byte reversal is off, so a read of address 0x80 returns 0.
- R2: A write to byte address 0x0C + 4*i, for i from 0 to 15, stores the data in `key_vec[32*i +: 32]`. The highest key address (0x48) therefore supplies the most significant word, `key_vec[511:480]`.
- R3: Bit 0 of the setting at address 0x80 enables byte reversal. While it is 1, a key write of bytes {b3,b2,b1,b0} is stored as {b0,b1,b2,b3}. While it is 0, the word is stored unchanged.
- R4: `key_valid` is 1 only when every one of the sixteen words has been written since the last clear or reset. Writing the same word again does not count twice.
- R5: A `clear` pulse zeroes `key_vec` and `key_valid` at the next clock edge. A key write in the same cycle is dropped. The byte-order setting keeps its value.
- R6: `rd_data` is registered and is valid in the cycle after `rd_en`. A read of any key address returns 0. A read of 0x80 returns the byte-order bit in bit 0 and zeros in all other bits.
- R7: A write to an address that is not word aligned, or that is neither a key address nor 0x80, changes neither the key, nor `key_valid`, nor the byte-order setting.
- R8: Writing zero to all sixteen key words leaves an all-zero key vector.
- R9: `key_vec` and `key_valid` change only in the cycle after a write or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| clear | input | 1 | Wipes the key and the written record |
| key_vec | output | 512 | Assembled key, word i in bits 32*i+31..32*i |
| key_valid | output | 1 | All sixteen words written since the last clear |

## Verification
The properties assume one access per cycle on each port and a key base address that is word aligned. They also assume that `clear` may coincide with a write. The stimulus drives one write at a time on the falling edge, with one deliberate case that raises a key write and `clear` together. The sweep covers every key word in ascending and descending order, with byte reversal both off and on. It also writes to aligned, misaligned and out-of-range addresses, so that each address class sits at the decode boundaries the properties rely on.

// File: rtl/hkb_pkg.sv
`timescale 1ns/1ps
package hkb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_KEY  = 2'd1,
    REG_CFG  = 2'd2
  } hkb_region_e;
endpackage

// File: rtl/hkb_decode.sv
`timescale 1ns/1ps
module hkb_decode #(
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 8,
  parameter int KEY_BASE  = 12,
  parameter int CFG_ADDR  = 128
) (
  input  logic [ADDR_W-1:0]            addr,
  output hkb_pkg::hkb_region_e         region,
  output logic [$clog2(NUM_WORDS)-1:0] idx
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] KB = ADDR_W'(KEY_BASE);
  localparam logic [ADDR_W-1:0] KE = ADDR_W'(KEY_BASE + 4 * NUM_WORDS);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CFG_ADDR);

  always_comb begin
    region = hkb_pkg::REG_NONE;
    if (addr[1:0] == 2'b00) begin
      if (addr >= KB && addr < KE) region = hkb_pkg::REG_KEY;
      else if (addr == CA)         region = hkb_pkg::REG_CFG;
    end
  end

  assign idx = IDX_W'((addr - KB) >> 2);
endmodule

// File: rtl/hkb_key_word.sv
`timescale 1ns/1ps
module hkb_key_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              we,
  input  logic              swap,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] q,
  output logic              written
);
  localparam int NB = WORD_W / hkb_pkg::BYTE_W;
  localparam int BW = hkb_pkg::BYTE_W;

  logic [WORD_W-1:0] rev;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_rev
      assign rev[b*BW +: BW] = din[(NB-1-b)*BW +: BW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q       <= '0;
      written <= 1'b0;
    end else if (we) begin
      q       <= swap ? rev : din;
      written <= 1'b1;
    end
  end
endmodule

// File: rtl/hmac_key_bank.sv
`timescale 1ns/1ps
module hmac_key_bank #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int KEY_BASE  = 12,
  parameter int CFG_ADDR  = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  input  logic                        clear,
  output logic [NUM_WORDS*WORD_W-1:0] key_vec,
  output logic                        key_valid
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CFG_ADDR);

  hkb_pkg::hkb_region_e wr_region;
  logic [IDX_W-1:0]     wr_idx;
  logic [NUM_WORDS-1:0] word_we;
  logic [NUM_WORDS-1:0] word_written;
  logic                 swap_q;

  hkb_decode #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
    .KEY_BASE(KEY_BASE), .CFG_ADDR(CFG_ADDR)
  ) u_wdec (
    .addr(wr_addr), .region(wr_region), .idx(wr_idx)
  );

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      assign word_we[w] = wr_en && (wr_region == hkb_pkg::REG_KEY) &&
                          (wr_idx == IDX_W'(w));
      hkb_key_word #(.WORD_W(WORD_W)) u_word (
        .clk(clk), .rst(rst), .clear(clear), .we(word_we[w]),
        .swap(swap_q), .din(wr_data),
        .q(key_vec[w*WORD_W +: WORD_W]), .written(word_written[w])
      );
    end
  endgenerate

  assign key_valid = &word_written;

  always_ff @(posedge clk) begin
    if (rst)
      swap_q <= 1'b0;
    else if (wr_en && wr_region == hkb_pkg::REG_CFG)
      swap_q <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en && rd_addr == CA)
      rd_data <= {{(WORD_W-1){1'b0}}, swap_q};
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/hkb_checker.sv
`timescale 1ns/1ps
module hkb_checker #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int KEY_BASE  = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [WORD_W-1:0]           wr_data,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           rd_addr,
  input logic [WORD_W-1:0]           rd_data,
  input logic                        clear,
  input logic [NUM_WORDS*WORD_W-1:0] key_vec,
  input logic                        key_valid,
  input logic                        swap_q
);
  localparam int NB = WORD_W / 8;
  localparam logic [ADDR_W-1:0] KB = ADDR_W'(KEY_BASE);
  localparam logic [ADDR_W-1:0] KE = ADDR_W'(KEY_BASE + 4 * NUM_WORDS);

  logic [WORD_W-1:0] data_rev;
  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_r
      assign data_rev[b*8 +: 8] = wr_data[WORD_W-8-b*8 +: 8];
    end
  endgenerate

  logic rd_key_hit;
  assign rd_key_hit = rd_en && rd_addr >= KB && rd_addr < KE;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (key_vec == '0 && !key_valid && !swap_q));

  // R5
  clear_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (key_vec == '0 && !key_valid));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !clear) |=> ($stable(key_vec) && $stable(key_valid)));

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(key_valid) |-> $past(wr_en));

  // R6
  key_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_key_hit |=> (rd_data == '0));

  // R3
  word0_order_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear && wr_addr == KB) |=>
      (key_vec[WORD_W-1:0] == ($past(swap_q) ? $past(data_rev) : $past(wr_data))));
endmodule

bind hmac_key_bank hkb_checker #(
  .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .KEY_BASE(KEY_BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .clear(clear),
  .key_vec(key_vec), .key_valid(key_valid), .swap_q(swap_q)
);

// File: tb/sim_hmac_key_bank.sv
`timescale 1ns/1ps
module sim_hmac_key_bank;
  localparam int NW = 16;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          clear = 1'b0;
  logic [511:0]  key_vec;
  logic          key_valid;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] exp_w [NW];

  always #2.5 clk = ~clk;

  hmac_key_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .clear(clear),
    .key_vec(key_vec), .key_valid(key_valid)
  );

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [511:0] packed_exp();
    logic [511:0] v;
    for (int i = 0; i < NW; i++) v[32*i +: 32] = exp_w[i];
    return v;
  endfunction

  function automatic logic [31:0] pat(input int i, input logic [31:0] seed);
    return seed ^ (32'h01030507 * (i + 1)) ^ {i[7:0], 24'h0};
  endfunction

  task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s key_vec act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < NW; i++) exp_w[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_vec("R1 reset", key_vec, '0);
    chk32("R1 valid", {31'b0, key_valid}, 32'd0);
    rd(8'h80, r);
    chk32("R1 cfg", r, 32'd0);

    // R2 / R4 ascending fill, swap off, word 0 rewritten
    for (int i = 0; i < NW; i++) begin
      exp_w[i] = pat(i, 32'hA55A0F0F);
      wr(8'(12 + 4*i), exp_w[i]);
      if (i == 0) begin
        wr(8'd12, exp_w[0]);
        chk32("R4 rewrite", {31'b0, key_valid}, 32'd0);
      end
      chk32("R4 valid", {31'b0, key_valid}, {31'b0, i == NW-1});
    end
    chk_vec("R2 fill", key_vec, packed_exp());
    chk32("R2 top word", key_vec[511:480], pat(15, 32'hA55A0F0F));

    // R6 key reads return zero
    for (int i = 0; i < NW; i++) begin
      rd(8'(12 + 4*i), r);
      chk32("R6 key read", r, 32'd0);
    end

    // R7 ignored writes
    wr(8'h08, 32'hDEADBEEF);
    wr(8'h4C, 32'hDEADBEEF);
    wr(8'h0D, 32'hDEADBEEF);
    wr(8'h81, 32'hFFFFFFFF);
    wr(8'hFC, 32'hDEADBEEF);
    chk_vec("R7 unmapped", key_vec, packed_exp());
    chk32("R7 valid", {31'b0, key_valid}, 32'd1);
    rd(8'h80, r);
    chk32("R7 cfg", r, 32'd0);

    // R5 clear
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int i = 0; i < NW; i++) exp_w[i] = '0;
    chk_vec("R5 clear", key_vec, '0);
    chk32("R5 valid", {31'b0, key_valid}, 32'd0);

    // R3 swap on, descending fill
    wr(8'h80, 32'h1);
    rd(8'h80, r);
    chk32("R6 cfg read", r, 32'd1);
    for (int i = NW-1; i >= 0; i--) begin
      exp_w[i] = bswap(pat(i, 32'h3C96C312));
      wr(8'(12 + 4*i), pat(i, 32'h3C96C312));
      chk32("R4 desc valid", {31'b0, key_valid}, {31'b0, i == 0});
    end
    chk_vec("R3 swapped", key_vec, packed_exp());

    // R5 clear beats simultaneous write, cfg kept
    @(negedge clk);
    clear = 1'b1; wr_en = 1'b1; wr_addr = 8'd24; wr_data = 32'h12345678;
    @(negedge clk);
    clear = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < NW; i++) exp_w[i] = '0;
    chk_vec("R5 clear+write", key_vec, '0);
    rd(8'h80, r);
    chk32("R5 cfg kept", r, 32'd1);

    // R8 zero fill, swap off
    wr(8'h80, 32'h0);
    for (int i = 0; i < NW; i++) wr(8'(12 + 4*i), 32'h0);
    chk_vec("R8 zero key", key_vec, '0);
    chk32("R8 valid", {31'b0, key_valid}, 32'd1);

    // R2 / R9 single word update, then hold while idle
    exp_w[5] = 32'hCAFE0105;
    wr(8'd32, 32'hCAFE0105);
    chk_vec("R2 word5", key_vec, packed_exp());
    repeat (4) @(negedge clk);
    chk_vec("R9 hold", key_vec, packed_exp());
    exp_w[5] = 32'h0;
    wr(8'd32, 32'h0);
    chk_vec("R8 rezero", key_vec, '0);

    finish_run();
  end
endmodule